// File: doc/BRIEF.md
# External Bus Handover Controller

This block decides who drives a shared external memory bus: the local processor, an external host, or a peer processor. While the local side owns the bus, the block lets local accesses run for a fixed number of cycles each. When the host asks for the bus, the block finishes any local access already in flight. It then turns off the output enables for the address, data, select and strobe lines. Only after that does it grant the bus to the host. The enable for the SDRAM control lines is never withdrawn.

While the host owns the bus and selects the block, the block drives a host ready line that holds the access off for a set number of wait states. That line can act as an open-drain pull-down or as a push-pull driver, chosen by a configuration input. A suspend input floats the shared lines in the cycle that follows it. It also freezes any local access until it is released.

Top module: `hbg_bus_handover`

## Requirements
- R1: After synchronous reset, `bus_oe` and `sdctl_oe` are 1, and `host_gnt`, `peer_gnt`, `loc_done`, `loc_stall` and `host_rdy_oe` are 0.
- R2: A host request sampled while the local side is idle clears `bus_oe` in the next cycle. `host_gnt` rises one cycle after that and stays 1 for as long as `host_req` stays high.
- R3: Once `host_req` is sampled low during a grant, `host_gnt` falls in the next cycle. `bus_oe` stays 0 for that cycle and returns to 1 one cycle later.
- R4: When host and peer requests are seen together while idle, the host is served first. `peer_gnt` stays 0 until the host has finished and the bus has come back.
- R5: A local access that has started takes ACC_LEN unsuspended cycles. `loc_done` is 1 in the last of them. A host request that arrives meanwhile gets no release until after `loc_done`.
- R6: `host_rdy_oe` is 0 whenever `host_cs` and `host_req` are not both 1.
- R7: Once in a host grant with `host_cs` high, `host_rdy` reads 0 for WAIT_CYC cycles and then 1 until `host_cs` drops.
- R8: With `rdy_active`=0 the ready pin is only pulled low: `host_rdy_oe` is 1 exactly in the wait cycles, with `host_rdy`=0. With `rdy_active`=1 the pin is driven for the whole window.
- R9: `susp` high in a cycle makes `bus_oe` 0 in the following cycle.
- R10: A local access makes no progress while `susp` is high. `loc_done` is never 1 in such a cycle, and `loc_stall` is 1 whenever `loc_req` is high and no progress is made.
- R11: `sdctl_oe` stays 1 through host grants, peer grants and suspends.
- R12: A peer request with no host request gets the same release, grant and return sequence through `peer_gnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| loc_req | input | 1 | local access wanted, held until `loc_done` |
| host_req | input | 1 | host asks for the bus |
| host_cs | input | 1 | host selects this block |
| peer_req | input | 1 | peer processor asks for the bus |
| susp | input | 1 | float the bus next cycle and freeze local access |
| rdy_active | input | 1 | 1: ready is push-pull, 0: open-drain |
| bus_oe | output | 1 | enable for address, data, select and strobe drivers |
| sdctl_oe | output | 1 | enable for SDRAM control drivers |
| host_gnt | output | 1 | bus granted to host |
| peer_gnt | output | 1 | bus granted to peer |
| loc_done | output | 1 | last cycle of a local access |
| loc_stall | output | 1 | local request pending without progress |
| host_rdy | output | 1 | ready value for the host |
| host_rdy_oe | output | 1 | ready pin driver enable |

## Verification
Two events can land in the same cycle: a host request that arrives while a local access is frozen by suspend, and the float that suspend forces. The bench raises `susp` and `host_req` together in the middle of a local access. It then checks that no release starts before `loc_done`, and that `bus_oe` follows both rules. A second collision puts host and peer requests in one idle cycle and judges the order of `host_gnt` and `peer_gnt` against a reference model that is compared every clock.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

    typedef enum logic [2:0] {
        OWN_IDLE,
        OWN_LOCAL,
        OWN_REL_HOST,
        OWN_HOST,
        OWN_RETURN,
        OWN_REL_PEER,
        OWN_PEER
    } own_e;

    function automatic logic local_drives(own_e s);
        return (s == OWN_IDLE) || (s == OWN_LOCAL);
    endfunction

    function automatic int cnt_width(int n);
        return (n > 1) ? $clog2(n + 1) : 1;
    endfunction

endpackage

// File: rtl/hbg_arbiter.sv
module hbg_arbiter
    import hbg_pkg::*;
#(
    parameter int ACC_LEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic loc_req,
    input  logic host_req,
    input  logic peer_req,
    input  logic susp,
    output own_e st_o,
    output logic bus_oe,
    output logic host_gnt,
    output logic peer_gnt,
    output logic loc_done,
    output logic loc_stall
);
    localparam int CW = cnt_width(ACC_LEN);
    localparam logic [CW-1:0] LAST = CW'(ACC_LEN - 1);

    own_e st, st_nx;
    logic [CW-1:0] cnt, cnt_nx;
    logic susp_q;
    logic advance;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= OWN_IDLE;
            cnt    <= '0;
            susp_q <= 1'b0;
        end else begin
            st     <= st_nx;
            cnt    <= cnt_nx;
            susp_q <= susp;
        end
    end

    assign advance = (st == OWN_LOCAL) && !susp;

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        case (st)
            OWN_IDLE: begin
                if (host_req)               st_nx = OWN_REL_HOST;
                else if (peer_req)          st_nx = OWN_REL_PEER;
                else if (loc_req && !susp) begin
                    st_nx  = OWN_LOCAL;
                    cnt_nx = LAST;
                end
            end
            OWN_LOCAL: begin
                if (!susp) begin
                    if (cnt == '0) st_nx  = OWN_IDLE;
                    else           cnt_nx = cnt - CW'(1);
                end
            end
            OWN_REL_HOST: st_nx = host_req ? OWN_HOST : OWN_IDLE;
            OWN_HOST:     if (!host_req) st_nx = OWN_RETURN;
            OWN_RETURN:   st_nx = OWN_IDLE;
            OWN_REL_PEER: st_nx = peer_req ? OWN_PEER : OWN_IDLE;
            OWN_PEER:     if (!peer_req) st_nx = OWN_RETURN;
            default:      st_nx = OWN_IDLE;
        endcase
    end

    assign st_o      = st;
    assign bus_oe    = local_drives(st) && !susp_q;
    assign host_gnt  = (st == OWN_HOST);
    assign peer_gnt  = (st == OWN_PEER);
    assign loc_done  = advance && (cnt == '0);
    assign loc_stall = loc_req && !advance;

    a_r2_gnt_needs_req: assert property (@(posedge clk) disable iff (rst)
        host_gnt |-> $past(host_req));
    a_r2_gnt_after_float: assert property (@(posedge clk) disable iff (rst)
        $rose(host_gnt) |-> $past(!bus_oe));
    a_r3_return_floats: assert property (@(posedge clk) disable iff (rst)
        $fell(host_gnt) |-> !bus_oe);
    a_r4_host_first: assert property (@(posedge clk) disable iff (rst)
        (st == OWN_IDLE && host_req && peer_req) |=> (st == OWN_REL_HOST));
    a_r5_local_holds: assert property (@(posedge clk) disable iff (rst)
        (st == OWN_LOCAL && !loc_done) |=> (st == OWN_LOCAL));
    a_r9_susp_floats: assert property (@(posedge clk) disable iff (rst)
        susp |=> !bus_oe);
    a_r10_no_done_susp: assert property (@(posedge clk) disable iff (rst)
        susp |-> !loc_done);

endmodule

// File: rtl/hbg_ready.sv
module hbg_ready #(
    parameter int WAIT_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic in_host,
    input  logic host_cs,
    input  logic host_req,
    input  logic rdy_active,
    output logic host_rdy,
    output logic host_rdy_oe
);
    logic win, rval;

    generate
        if (WAIT_CYC == 0) begin : g_nowait
            assign rval = 1'b1;
        end else begin : g_wait
            localparam int WW = hbg_pkg::cnt_width(WAIT_CYC);
            logic [WW-1:0] wcnt;
            always_ff @(posedge clk) begin
                if (rst)                      wcnt <= WW'(WAIT_CYC);
                else if (in_host && host_cs) begin
                    if (wcnt != '0)           wcnt <= wcnt - WW'(1);
                end else                      wcnt <= WW'(WAIT_CYC);
            end
            assign rval = (wcnt == '0);
        end
    endgenerate

    assign win         = host_cs && host_req;
    assign host_rdy    = win && rval;
    assign host_rdy_oe = win && (rdy_active || !rval);

    a_r6_window: assert property (@(posedge clk) disable iff (rst)
        host_rdy_oe |-> (host_cs && host_req));
    a_r8_open_drain: assert property (@(posedge clk) disable iff (rst)
        (host_rdy_oe && !rdy_active) |-> !host_rdy);

endmodule

// File: rtl/hbg_bus_handover.sv
module hbg_bus_handover
    import hbg_pkg::*;
#(
    parameter int ACC_LEN  = 3,
    parameter int WAIT_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic loc_req,
    input  logic host_req,
    input  logic host_cs,
    input  logic peer_req,
    input  logic susp,
    input  logic rdy_active,
    output logic bus_oe,
    output logic sdctl_oe,
    output logic host_gnt,
    output logic peer_gnt,
    output logic loc_done,
    output logic loc_stall,
    output logic host_rdy,
    output logic host_rdy_oe
);
    own_e st;

    hbg_arbiter #(.ACC_LEN(ACC_LEN)) u_arb (
        .clk(clk), .rst(rst), .loc_req(loc_req), .host_req(host_req),
        .peer_req(peer_req), .susp(susp), .st_o(st), .bus_oe(bus_oe),
        .host_gnt(host_gnt), .peer_gnt(peer_gnt), .loc_done(loc_done),
        .loc_stall(loc_stall)
    );

    hbg_ready #(.WAIT_CYC(WAIT_CYC)) u_rdy (
        .clk(clk), .rst(rst), .in_host(st == OWN_HOST), .host_cs(host_cs),
        .host_req(host_req), .rdy_active(rdy_active), .host_rdy(host_rdy),
        .host_rdy_oe(host_rdy_oe)
    );

    // R11: SDRAM control drivers are never handed over
    assign sdctl_oe = 1'b1;

    a_r12_peer_excl: assert property (@(posedge clk) disable iff (rst)
        !(host_gnt && peer_gnt));

endmodule

// File: tb/test_hbg_bus_handover.sv
module test_hbg_bus_handover;
    localparam int ACC = 3;
    localparam int WT  = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic loc_req = 0, host_req = 0, host_cs = 0, peer_req = 0, susp = 0, rdy_active = 0;
    logic bus_oe, sdctl_oe, host_gnt, peer_gnt, loc_done, loc_stall, host_rdy, host_rdy_oe;

    int total = 0, bad = 0, cycles = 0;
    // reference model: 0 idle 1 local 2 relhost 3 host 4 return 5 relpeer 6 peer
    int mst = 0, mcnt = 0, mw = WT;
    logic msq = 0, lr = 0;

    always #10 clk = ~clk;

    hbg_bus_handover #(.ACC_LEN(ACC), .WAIT_CYC(WT)) i_hbg_bus_handover (
        .clk(clk), .rst(rst), .loc_req(loc_req), .host_req(host_req), .host_cs(host_cs),
        .peer_req(peer_req), .susp(susp), .rdy_active(rdy_active), .bus_oe(bus_oe),
        .sdctl_oe(sdctl_oe), .host_gnt(host_gnt), .peer_gnt(peer_gnt), .loc_done(loc_done),
        .loc_stall(loc_stall), .host_rdy(host_rdy), .host_rdy_oe(host_rdy_oe)
    );

    task automatic chk(string tag, string nm, logic got, logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s cycle %0d: got %0b exp %0b", tag, nm, cycles, got, exp);
        end
    endtask

    task automatic cyc(logic hr, logic cs, logic pr, logic sp, logic ls, string tag);
        logic e_done, win, rv;
        host_req = hr; host_cs = cs; peer_req = pr; susp = sp;
        if (ls) lr = 1'b1;
        loc_req = lr;
        #2;
        e_done = (mst == 1) && !sp && (mcnt == 0);
        win = cs && hr;
        rv = (mw == 0);
        chk(tag, "bus_oe", bus_oe, (mst <= 1) && !msq);
        chk("R11", "sdctl_oe", sdctl_oe, 1'b1);
        chk(tag, "host_gnt", host_gnt, mst == 3);
        chk(tag, "peer_gnt", peer_gnt, mst == 6);
        chk(tag, "loc_done", loc_done, e_done);
        chk(tag, "loc_stall", loc_stall, lr && !((mst == 1) && !sp));
        chk(tag, "host_rdy", host_rdy, win && rv);
        chk(tag, "host_rdy_oe", host_rdy_oe, win && (rdy_active || !rv));
        // next model state
        mw = (mst == 3 && cs) ? ((mw > 0) ? mw - 1 : 0) : WT;
        case (mst)
            0: if (hr) mst = 2; else if (pr) mst = 5;
               else if (lr && !sp) begin mst = 1; mcnt = ACC - 1; end
            1: if (!sp) begin if (mcnt == 0) mst = 0; else mcnt--; end
            2: mst = hr ? 3 : 0;
            3: if (!hr) mst = 4;
            4: mst = 0;
            5: mst = pr ? 6 : 0;
            6: if (!pr) mst = 4;
            default: mst = 0;
        endcase
        msq = sp;
        if (e_done) lr = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            bad++; total++;
            $display("FAIL watchdog: got %0d cycles exp below 20000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1", "bus_oe", bus_oe, 1'b1);
        chk("R1", "host_gnt", host_gnt, 1'b0);
        chk("R1", "peer_gnt", peer_gnt, 1'b0);
        chk("R1", "loc_stall", loc_stall, 1'b0);
        chk("R1", "host_rdy_oe", host_rdy_oe, 1'b0);
        @(negedge clk);
        repeat (2) cyc(0, 0, 0, 0, 0, "R1");
        // R5 plain local access
        cyc(0, 0, 0, 0, 1, "R5");
        repeat (5) cyc(0, 0, 0, 0, 0, "R5");
        // R5 host arrives mid-access, R2 grant, R7 wait states, R3 return
        cyc(0, 0, 0, 0, 1, "R5");
        repeat (3) cyc(1, 0, 0, 0, 0, "R5");
        repeat (2) cyc(1, 0, 0, 0, 0, "R2");
        repeat (5) cyc(1, 1, 0, 0, 0, "R7");
        cyc(1, 0, 0, 0, 0, "R7");
        repeat (4) cyc(0, 0, 0, 0, 0, "R3");
        // R8 push-pull ready
        rdy_active = 1'b1;
        repeat (3) cyc(1, 0, 0, 0, 0, "R8");
        repeat (5) cyc(1, 1, 0, 0, 0, "R8");
        repeat (3) cyc(0, 0, 0, 0, 0, "R8");
        rdy_active = 1'b0;
        // R4 host and peer together, then R12 peer alone
        repeat (5) cyc(1, 0, 1, 0, 0, "R4");
        repeat (6) cyc(0, 0, 1, 0, 0, "R12");
        repeat (4) cyc(0, 0, 0, 0, 0, "R12");
        // R10 suspend mid-access, R9 suspend while idle
        cyc(0, 0, 0, 0, 1, "R10");
        cyc(0, 0, 0, 0, 0, "R10");
        repeat (3) cyc(0, 0, 0, 1, 0, "R10");
        repeat (5) cyc(0, 0, 0, 0, 0, "R10");
        cyc(0, 0, 0, 1, 0, "R9");
        repeat (3) cyc(0, 0, 0, 0, 0, "R9");
        // R6 select without host request
        repeat (3) cyc(0, 1, 0, 0, 0, "R6");
        cyc(0, 0, 0, 0, 0, "R6");
        // collision: suspend and host request together during local access
        cyc(0, 0, 0, 0, 1, "R10");
        repeat (2) cyc(1, 0, 0, 1, 0, "R10");
        repeat (6) cyc(1, 1, 0, 0, 0, "R5");
        repeat (4) cyc(0, 0, 0, 0, 0, "R3");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule